// File: doc/BRIEF.md
# Dual Execute Unit Dispatcher

This block stands in for the execute stage of an in-order pipeline. It has two identical execute units, so that two long operations can run at the same time. Fetch, decode, operand fetch and write-back each stay a single unit. Each operation arrives from the operand-fetch side on a valid/ready handshake. It carries a tag and an execute latency in clocks. The block sends consecutive operations to unit 0 and unit 1 in turn. Each unit loads the latency into a down-counter and reports completion when the count runs out. No arithmetic is done: the tag simply passes through the unit.

Finished results go to write-back over a second valid/ready handshake, strictly in the order they were accepted. A younger result that finishes early is held inside its unit until every older result has left. A held result keeps its unit occupied. The dispatcher takes a new operation only when the unit whose turn it is can accept it.

Each unit runs a three-state machine:
- IDLE goes to BUSY on a load with latency of 2 or more, or straight to DONE on a load with latency 0 or 1.
- BUSY counts down and goes to DONE when the count reaches 1.
- DONE stays put until its result is taken. When the result is taken it goes back to IDLE, or it restarts in BUSY or DONE if a new operation is loaded in that same cycle.

Top module: `dual_exec_dispatcher`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. The first accepted operation goes to unit 0, and its result leaves with `out_unit` = 0.
- R2: Accepted operations go to unit 0 and unit 1 in strict turn. Each result reports on `out_unit` (0 or 1) the unit that ran it.
- R3: Suppose an operation with latency L is accepted on clock edge k, all older results have left, and `out_ready` is held at 1. Its result is then taken on edge k+L. A latency of 0 behaves as 1, and the widest latency value works the same way.
- R4: `in_ready` is high only when the unit whose turn it is can take the operation. That unit must be idle, or hold a result that is being taken in the same cycle.
- R5: Results leave in acceptance order, even when a younger operation finishes before an older one.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_tag` and `out_unit` stay unchanged, and the held unit accepts no new operation.
- R7: With back-to-back input and latency 4, two results leave every 4 clocks. With latency 1, one result leaves per clock, which is no better than a single unit.
- R8: When operations arrive only once every 5 clocks with latency 4, results leave once every 5 clocks.
- R9: Accepted but not yet retired operations never number more than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered by operand fetch |
| in_ready | output | 1 | Operation will be accepted this cycle |
| in_tag | input | TAG_W | Tag of the offered operation |
| in_lat | input | LAT_W | Execute latency in clocks (0 treated as 1) |
| out_valid | output | 1 | Oldest result is ready for write-back |
| out_ready | input | 1 | Write-back takes the result this cycle |
| out_tag | output | TAG_W | Tag of the presented result |
| out_unit | output | 1 | Unit (0 or 1) that executed the result |

## Verification
There are several ways a wrong internal state would show at the ports:
- A wrong turn pointer sends work to the busy unit. This shows up within one handshake, as a stalled `in_ready` or an `out_unit` that repeats.
- A wrong read pointer lets a younger tag overtake an older one. The out-of-order tag appears at the very next retirement.
- A counter that is off by one moves the retire edge away from k+L. The directed latency and throughput runs measure that edge exactly, down to the clock.
- A held result that drops or changes while write-back stalls shows up in the first stalled cycle.

// File: rtl/dual_exec_pkg.sv
package dual_exec_pkg;

    typedef enum logic [1:0] {
        U_IDLE = 2'd0,
        U_BUSY = 2'd1,
        U_DONE = 2'd2
    } unit_state_e;

endpackage

// File: rtl/dual_exec_unit.sv
module dual_exec_unit
    import dual_exec_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             release_i,
    output logic             free_o,
    output logic             done_o,
    output logic [TAG_W-1:0] tag_o
);

    unit_state_e      state_q, state_nx;
    logic [LAT_W-1:0] cnt_q, cnt_nx;
    logic [TAG_W-1:0] tag_q, tag_nx;
    logic             short_op;

    assign short_op = (lat_i <= LAT_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= U_IDLE;
            cnt_q   <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            tag_q   <= tag_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        tag_nx   = tag_q;
        unique case (state_q)
            U_IDLE: begin
                if (load_i) begin
                    tag_nx   = tag_i;
                    state_nx = short_op ? U_DONE : U_BUSY;
                    cnt_nx   = short_op ? '0 : lat_i - LAT_W'(1);
                end
            end
            U_BUSY: begin
                if (cnt_q <= LAT_W'(1)) begin
                    state_nx = U_DONE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt_q - LAT_W'(1);
                end
            end
            U_DONE: begin
                if (release_i) begin
                    if (load_i) begin
                        tag_nx   = tag_i;
                        state_nx = short_op ? U_DONE : U_BUSY;
                        cnt_nx   = short_op ? '0 : lat_i - LAT_W'(1);
                    end else begin
                        state_nx = U_IDLE;
                    end
                end
            end
            default: state_nx = U_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        free_o = (state_q == U_IDLE) || ((state_q == U_DONE) && release_i);
        done_o = (state_q == U_DONE);
        tag_o  = tag_q;
    end

endmodule

// File: rtl/dual_exec_dispatch.sv
module dual_exec_dispatch #(
    parameter int NUM_UNITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [NUM_UNITS-1:0] free_i,
    output logic                 in_ready,
    output logic [NUM_UNITS-1:0] load_o
);

    localparam int PTR_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

    logic [PTR_W-1:0] turn_q;
    logic             take;

    assign in_ready = free_i[turn_q];
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn_q <= '0;
        end else if (take) begin
            turn_q <= (turn_q == PTR_W'(NUM_UNITS - 1)) ? '0 : turn_q + PTR_W'(1);
        end
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_load
        assign load_o[g] = take && (turn_q == PTR_W'(g));
    end

endmodule

// File: rtl/dual_exec_retire.sv
module dual_exec_retire #(
    parameter int NUM_UNITS = 2,
    parameter int TAG_W     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_UNITS-1:0]             done_i,
    input  logic [NUM_UNITS-1:0][TAG_W-1:0]  tag_i,
    input  logic                             out_ready,
    output logic                             out_valid,
    output logic [TAG_W-1:0]                 out_tag,
    output logic                             out_unit,
    output logic [NUM_UNITS-1:0]             release_o
);

    localparam int PTR_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

    logic [PTR_W-1:0] head_q;
    logic             leave;

    assign out_valid = done_i[head_q];
    assign out_tag   = tag_i[head_q];
    assign out_unit  = head_q[0];
    assign leave     = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (leave) begin
            head_q <= (head_q == PTR_W'(NUM_UNITS - 1)) ? '0 : head_q + PTR_W'(1);
        end
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_rel
        assign release_o[g] = leave && (head_q == PTR_W'(g));
    end

endmodule

// File: rtl/dual_exec_dispatcher.sv
module dual_exec_dispatcher #(
    parameter int TAG_W = 8,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [LAT_W-1:0] in_lat,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_unit
);

    localparam int NUM_UNITS = 2;

    logic [NUM_UNITS-1:0]            unit_free;
    logic [NUM_UNITS-1:0]            unit_done;
    logic [NUM_UNITS-1:0]            unit_load;
    logic [NUM_UNITS-1:0]            unit_rel;
    logic [NUM_UNITS-1:0][TAG_W-1:0] unit_tag;

    dual_exec_dispatch #(.NUM_UNITS(NUM_UNITS)) u_dispatch (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .free_i   (unit_free),
        .in_ready (in_ready),
        .load_o   (unit_load)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        dual_exec_unit #(.TAG_W(TAG_W), .LAT_W(LAT_W)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (unit_load[g]),
            .lat_i     (in_lat),
            .tag_i     (in_tag),
            .release_i (unit_rel[g]),
            .free_o    (unit_free[g]),
            .done_o    (unit_done[g]),
            .tag_o     (unit_tag[g])
        );
    end

    dual_exec_retire #(.NUM_UNITS(NUM_UNITS), .TAG_W(TAG_W)) u_retire (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (unit_done),
        .tag_i     (unit_tag),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_tag   (out_tag),
        .out_unit  (out_unit),
        .release_o (unit_rel)
    );

endmodule

// File: rtl/dual_exec_chk.sv
module dual_exec_chk #(
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [TAG_W-1:0] out_tag,
    input logic             out_unit
);

    logic [2:0] occ_q;
    logic       seen_q;
    logic       last_unit_q;
    logic       acc, ret;

    assign acc = in_valid && in_ready;
    assign ret = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q       <= '0;
            seen_q      <= 1'b0;
            last_unit_q <= 1'b0;
        end else begin
            occ_q <= occ_q + {2'b0, acc} - {2'b0, ret};
            if (ret) begin
                seen_q      <= 1'b1;
                last_unit_q <= out_unit;
            end
        end
    end

    assert_occupancy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= 3'd2);

    assert_valid_backed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (occ_q != 3'd0));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_unit)));

    assert_retire_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && seen_q) |-> (out_unit != last_unit_q));

    assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ_q == 3'd2) && !ret) |-> !in_ready);

endmodule

bind dual_exec_dispatcher dual_exec_chk #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tag   (out_tag),
    .out_unit  (out_unit)
);

// File: tb/dual_exec_dispatcher_bench.sv
module dual_exec_dispatcher_bench;

    localparam int TAG_W = 8;
    localparam int LAT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [TAG_W-1:0] in_tag = '0;
    logic [LAT_W-1:0] in_lat = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [TAG_W-1:0] out_tag;
    logic             out_unit;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int acc_log [0:255];
    int ret_log [0:255];
    int q_tag[$], q_lat[$], q_edge[$], q_unit[$];
    int exp_turn = 0;
    int max_occ = 0;
    bit done_flag = 0;

    dual_exec_dispatcher #(.TAG_W(TAG_W), .LAT_W(LAT_W)) u_dual_exec_dispatcher (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_lat(in_lat), .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_unit(out_unit)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int eff_lat(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    // Scoreboard monitor, sampled between edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (q_tag.size() == 0) begin
                    chk(0, "R5 retire with nothing outstanding", 1, 0);
                end else begin
                    int t, l, e, u;
                    t = q_tag.pop_front(); l = q_lat.pop_front();
                    e = q_edge.pop_front(); u = q_unit.pop_front();
                    chk(out_tag == t, "R5 retire order tag", out_tag, t);
                    chk(out_unit == u, "R2 unit of result", out_unit, u);
                    chk((cyc + 1 - e) >= eff_lat(l), "R3 latency lower bound", cyc + 1 - e, eff_lat(l));
                    ret_log[out_tag] = cyc + 1;
                end
            end
            if (in_valid && in_ready) begin
                q_tag.push_back(in_tag); q_lat.push_back(in_lat);
                q_edge.push_back(cyc + 1); q_unit.push_back(exp_turn);
                acc_log[in_tag] = cyc + 1;
                exp_turn ^= 1;
            end
            if (q_tag.size() > max_occ) max_occ = q_tag.size();
        end
    end

    task automatic send(input int t, input int l, output int waited);
        waited = 0;
        @(negedge clk);
        in_valid = 1'b1; in_tag = TAG_W'(t); in_lat = LAT_W'(l);
        #1;
        while (!in_ready) begin
            waited++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        out_ready = 1'b1;
        while (q_tag.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int w;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

        // R1 / R3 exact latencies, unit 0 first
        out_ready = 1'b1;
        send(8'hC0, 3, w); drain();
        chk(ret_log[8'hC0] - acc_log[8'hC0] == 3, "R3 latency 3", ret_log[8'hC0] - acc_log[8'hC0], 3);
        send(8'hC1, 0, w); drain();
        chk(ret_log[8'hC1] - acc_log[8'hC1] == 1, "R3 latency 0 as 1", ret_log[8'hC1] - acc_log[8'hC1], 1);
        send(8'hC2, 1, w); drain();
        chk(ret_log[8'hC2] - acc_log[8'hC2] == 1, "R3 latency 1", ret_log[8'hC2] - acc_log[8'hC2], 1);
        send(8'hC3, 15, w); drain();
        chk(ret_log[8'hC3] - acc_log[8'hC3] == 15, "R3 latency max", ret_log[8'hC3] - acc_log[8'hC3], 15);

        // R5 younger finishes first but waits
        send(8'hD0, 8, w); send(8'hD1, 1, w); drain();
        chk(ret_log[8'hD0] - acc_log[8'hD0] == 8, "R5 older latency", ret_log[8'hD0] - acc_log[8'hD0], 8);
        chk(ret_log[8'hD1] - ret_log[8'hD0] == 1, "R5 younger follows", ret_log[8'hD1] - ret_log[8'hD0], 1);

        // R4 next unit busy blocks input
        send(8'hE0, 6, w); send(8'hE1, 6, w); send(8'hE2, 1, w);
        chk(w == 4, "R4 stall cycles", w, 4);
        drain();
        chk(acc_log[8'hE2] == ret_log[8'hE0], "R4 accept on release", acc_log[8'hE2], ret_log[8'hE0]);

        // R6 hold while write-back stalls
        out_ready = 1'b0;
        send(8'hF0, 2, w); send(8'hF1, 2, w);
        @(negedge clk);
        in_valid = 1'b1; in_tag = 8'hF2; in_lat = 4'd1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            chk(out_valid == 1'b1, "R6 valid held", out_valid, 1);
            chk(out_tag == 8'hF0, "R6 tag held", out_tag, 8'hF0);
            chk(in_ready == 1'b0, "R6 held unit blocks input", in_ready, 0);
        end
        @(negedge clk); out_ready = 1'b1; #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1; in_valid = 1'b0;
        drain();

        // R7 stream latency 4 then latency 1
        for (int i = 0; i < 10; i++) send(8'h90 + i, 4, w);
        drain();
        for (int i = 2; i < 8; i++)
            chk(ret_log[8'h90 + i + 2] - ret_log[8'h90 + i] == 4, "R7 two per four clocks",
                ret_log[8'h90 + i + 2] - ret_log[8'h90 + i], 4);
        for (int i = 0; i < 10; i++) send(8'hB0 + i, 1, w);
        drain();
        for (int i = 1; i < 9; i++)
            chk(ret_log[8'hB0 + i + 1] - ret_log[8'hB0 + i] == 1, "R7 one per clock at latency 1",
                ret_log[8'hB0 + i + 1] - ret_log[8'hB0 + i], 1);

        // R8 slow operand fetch: one every 5 clocks
        for (int i = 0; i < 8; i++) begin
            send(8'h70 + i, 4, w);
            repeat (4) @(posedge clk);
        end
        drain();
        for (int i = 1; i < 7; i++)
            chk(ret_log[8'h70 + i + 1] - ret_log[8'h70 + i] == 5, "R8 rate set by input",
                ret_log[8'h70 + i + 1] - ret_log[8'h70 + i], 5);

        // Random traffic, scoreboarded for R2, R3, R5
        begin
            int sent = 0;
            bit pending = 0;
            while (sent < 400) begin
                @(negedge clk);
                if (!pending && ($urandom_range(0, 3) != 0)) begin
                    pending = 1;
                    in_tag = TAG_W'(sent & 8'h7F);
                    in_lat = LAT_W'($urandom_range(0, 7));
                end
                in_valid = pending;
                out_ready = ($urandom_range(0, 9) < 7);
                #1;
                if (in_valid && in_ready) begin
                    pending = 0;
                    sent++;
                end
            end
            @(negedge clk); in_valid = 1'b0;
        end
        drain();
        chk(max_occ <= 2, "R9 outstanding limit", max_occ, 2);
        chk(q_tag.size() == 0, "R5 all retired", q_tag.size(), 0);

        finish_run();
    end

endmodule